// File: doc/BRIEF.md
# Compare-Latch Conditional Branch Unit

This block resolves conditional control flow for a processor whose compare instruction sets no flag bits. Instead, a compare strobe copies its two 32-bit register operands into a pair of hidden operand latches. A later conditional branch names one of ten relations and tests it against whatever those latches hold at that moment. Signed, unsigned and equality relations are therefore all decided when the branch executes, not when the compare does.

When the branch is taken, the next program counter is the address of the following instruction plus a 10-bit signed displacement counted in 16-bit instruction units. When it is not taken, execution falls through to the following instruction. Condition codes outside the defined ten do not branch. Instead they raise an illegal-instruction flag, and the next PC points back at the faulting branch so that a trap handler can find it.

Each branch result is registered and appears one clock edge after the branch strobe, together with a one-cycle completion pulse.

Top module: `cbr_branch_unit`

## Requirements
- R1: After reset, both operand latches hold zero, and `next_pc`, `taken`, `illegal` and `br_done` are all zero. A branch on code 0x0 issued straight after reset is therefore taken.
- R2: A cycle with `cmp_valid` high loads `cmp_a` into operand latch A and `cmp_b` into operand latch B at that clock edge. If `br_valid` is low in that cycle, none of `next_pc`, `taken`, `illegal` or `br_done` changes.
- R3: For a taken branch, the 10-bit `br_offset` is sign-extended from bit 9, multiplied by two, and added to `pc + 2`, with the sum wrapping modulo 2^32.
- R4: For a legal branch that is not taken, `next_pc` is `pc + 2` and `taken` is 0.
- R5: Code 0x0 branches when latch A equals latch B. Code 0x1 branches when they differ.
- R6: Codes 0x2, 0x3, 0x6 and 0x7 compare latch A with latch B as two's-complement numbers, and branch on A<B, A>B, A>=B and A<=B respectively.
- R7: Codes 0x4, 0x5, 0x8 and 0x9 compare latch A with latch B as unsigned numbers, and branch on A<B, A>B, A>=B and A<=B respectively.
- R8: Codes 0xA to 0xF set `illegal` to 1, hold `taken` at 0, and set `next_pc` to the `pc` of the branch.
- R9: When `cmp_valid` and `br_valid` are both high in the same cycle, the branch is evaluated on the latch values from before that edge, and the new operands are used only by later branches.
- R10: All branch results register at the clock edge that samples `br_valid`, and `br_done` pulses high for exactly that one cycle. In a cycle without `br_valid`, `taken`, `illegal` and `br_done` return to 0 and `next_pc` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare strobe: latch both operands |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand |
| br_valid | input | 1 | Conditional branch strobe |
| br_cond | input | 4 | Condition code (0x0 to 0x9 legal) |
| br_offset | input | 10 | Signed displacement in halfwords |
| pc | input | 32 | Address of the branch instruction |
| next_pc | output | 32 | Registered next program counter |
| taken | output | 1 | Registered branch-taken flag |
| illegal | output | 1 | Registered illegal-condition flag |
| br_done | output | 1 | One-cycle pulse marking a branch result |

## Verification
Operand latches take new values at the edge that samples `cmp_valid`. A branch result appears on the outputs at the edge that samples `br_valid`, so it is due exactly one edge after the inputs are applied. The bench drives every input on a falling edge and advances its reference model at the same moment. It compares all four outputs at the next falling edge, half a period after the register update. In this way every compare, including cycles with no branch and same-cycle compare-plus-branch, lands on the single cycle where the result must be present.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    localparam int CC_W = 4;

    typedef enum logic [CC_W-1:0] {
        CC_EQ  = 4'h0,
        CC_NE  = 4'h1,
        CC_LT  = 4'h2,
        CC_GT  = 4'h3,
        CC_LTU = 4'h4,
        CC_GTU = 4'h5,
        CC_GE  = 4'h6,
        CC_LE  = 4'h7,
        CC_GEU = 4'h8,
        CC_LEU = 4'h9
    } cc_e;

    localparam logic [CC_W-1:0] CC_LAST_LEGAL = 4'h9;

endpackage

// File: rtl/cbr_opnd_latch.sv
module cbr_opnd_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] lat_a,
    output logic [W-1:0] lat_b
);

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
    } opnd_t;

    opnd_t opnd_d, opnd_q;

    always_comb begin
        opnd_d = opnd_q;
        if (load) begin
            opnd_d.a = in_a;
            opnd_d.b = in_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q <= '0;
        end else begin
            opnd_q <= opnd_d;
        end
    end

    assign lat_a = opnd_q.a;
    assign lat_b = opnd_q.b;

endmodule

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
    import cbr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]    op_a,
    input  logic [W-1:0]    op_b,
    input  logic [CC_W-1:0] cond,
    output logic            hit,
    output logic            bad
);

    logic is_eq;
    logic s_lt;
    logic u_lt;
    cc_e  code;

    // One subtractor-free magnitude compare per signedness; the
    // remaining relations are derived from lt and eq.
    always_comb begin
        is_eq = (op_a == op_b);
        u_lt  = (op_a < op_b);
        s_lt  = ($signed(op_a) < $signed(op_b));
    end

    assign code = cc_e'(cond);
    assign bad  = (cond > CC_LAST_LEGAL);

    always_comb begin
        hit = 1'b0;
        unique case (code)
            CC_EQ:  hit = is_eq;
            CC_NE:  hit = !is_eq;
            CC_LT:  hit = s_lt;
            CC_GT:  hit = !s_lt && !is_eq;
            CC_GE:  hit = !s_lt;
            CC_LE:  hit = s_lt || is_eq;
            CC_LTU: hit = u_lt;
            CC_GTU: hit = !u_lt && !is_eq;
            CC_GEU: hit = !u_lt;
            CC_LEU: hit = u_lt || is_eq;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbr_target.sv
module cbr_target #(
    parameter int W          = 32,
    parameter int OFF_W      = 10,
    parameter int INSN_BYTES = 2
) (
    input  logic [W-1:0]     pc,
    input  logic [OFF_W-1:0] offset,
    output logic [W-1:0]     seq_pc,
    output logic [W-1:0]     jump_pc
);

    localparam int           SHIFT = $clog2(INSN_BYTES);
    localparam logic [W-1:0] STEP  = W'(INSN_BYTES);

    logic [W-1:0] off_ext;
    logic [W-1:0] off_scaled;

    generate
        if (OFF_W < W) begin : g_sext
            assign off_ext = {{(W-OFF_W){offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            assign off_ext = offset[W-1:0];
        end
    endgenerate

    assign off_scaled = off_ext << SHIFT;
    assign seq_pc     = pc + STEP;
    assign jump_pc    = seq_pc + off_scaled;

endmodule

// File: rtl/cbr_branch_unit.sv
module cbr_branch_unit
    import cbr_pkg::*;
#(
    parameter int W          = 32,
    parameter int OFF_W      = 10,
    parameter int INSN_BYTES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_valid,
    input  logic [W-1:0]     cmp_a,
    input  logic [W-1:0]     cmp_b,
    input  logic             br_valid,
    input  logic [CC_W-1:0]  br_cond,
    input  logic [OFF_W-1:0] br_offset,
    input  logic [W-1:0]     pc,
    output logic [W-1:0]     next_pc,
    output logic             taken,
    output logic             illegal,
    output logic             br_done
);

    typedef struct packed {
        logic [W-1:0] npc;
        logic         taken;
        logic         illegal;
        logic         done;
    } res_t;

    logic [W-1:0] lat_a;
    logic [W-1:0] lat_b;
    logic         cond_hit;
    logic         cond_bad;
    logic [W-1:0] seq_pc;
    logic [W-1:0] jump_pc;
    res_t         res_d, res_q;

    cbr_opnd_latch #(.W(W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmp_valid),
        .in_a  (cmp_a),
        .in_b  (cmp_b),
        .lat_a (lat_a),
        .lat_b (lat_b)
    );

    cbr_cond_eval #(.W(W)) u_eval (
        .op_a (lat_a),
        .op_b (lat_b),
        .cond (br_cond),
        .hit  (cond_hit),
        .bad  (cond_bad)
    );

    cbr_target #(.W(W), .OFF_W(OFF_W), .INSN_BYTES(INSN_BYTES)) u_tgt (
        .pc      (pc),
        .offset  (br_offset),
        .seq_pc  (seq_pc),
        .jump_pc (jump_pc)
    );

    always_comb begin
        res_d         = res_q;
        res_d.taken   = 1'b0;
        res_d.illegal = 1'b0;
        res_d.done    = 1'b0;
        if (br_valid) begin
            res_d.done = 1'b1;
            if (cond_bad) begin
                res_d.illegal = 1'b1;
                res_d.npc     = pc;
            end else if (cond_hit) begin
                res_d.taken = 1'b1;
                res_d.npc   = jump_pc;
            end else begin
                res_d.npc = seq_pc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign next_pc = res_q.npc;
    assign taken   = res_q.taken;
    assign illegal = res_q.illegal;
    assign br_done = res_q.done;

endmodule

// File: rtl/cbr_branch_unit_chk.sv
module cbr_branch_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cmp_valid,
    input logic [W-1:0] cmp_a,
    input logic [W-1:0] cmp_b,
    input logic         br_valid,
    input logic [3:0]   br_cond,
    input logic [W-1:0] pc,
    input logic [W-1:0] next_pc,
    input logic         taken,
    input logic         illegal,
    input logic         done,
    input logic [W-1:0] lat_a,
    input logic [W-1:0] lat_b
);

    p_latch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> (lat_a == $past(cmp_a)) && (lat_b == $past(cmp_b)));

    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(lat_a) && $stable(lat_b));

    p_fall_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_cond <= 4'h9) |=>
            (!illegal && (taken || next_pc == $past(pc) + 32'd2)));

    p_eq_old_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_cond == 4'h0) |=> (taken == ($past(lat_a) == $past(lat_b))));

    p_illegal_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_cond > 4'h9) |=> (illegal && !taken && next_pc == $past(pc)));

    p_illegal_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !taken);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> done);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> (!done && !taken && !illegal && $stable(next_pc)));

endmodule

bind cbr_branch_unit cbr_branch_unit_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .br_valid  (br_valid),
    .br_cond   (br_cond),
    .pc        (pc),
    .next_pc   (next_pc),
    .taken     (taken),
    .illegal   (illegal),
    .done      (br_done),
    .lat_a     (lat_a),
    .lat_b     (lat_b)
);

// File: tb/test_cbr_branch_unit.sv
module test_cbr_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [31:0] cmp_a = '0;
    logic [31:0] cmp_b = '0;
    logic        br_valid = 1'b0;
    logic [3:0]  br_cond = '0;
    logic [9:0]  br_offset = '0;
    logic [31:0] pc = '0;
    logic [31:0] next_pc;
    logic        taken;
    logic        illegal;
    logic        br_done;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_a = '0, m_b = '0, m_npc = '0;
    logic        m_tk = 0, m_ill = 0, m_done = 0;

    always #10 clk = ~clk;

    cbr_branch_unit i_cbr_branch_unit (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_a(cmp_a),
        .cmp_b(cmp_b), .br_valid(br_valid), .br_cond(br_cond),
        .br_offset(br_offset), .pc(pc), .next_pc(next_pc), .taken(taken),
        .illegal(illegal), .br_done(br_done)
    );

    function automatic bit rel(input int c, input logic [31:0] a, input logic [31:0] b);
        int signed   sa = a;
        int signed   sb = b;
        longint      ua = {32'd0, a};
        longint      ub = {32'd0, b};
        case (c)
            0: return ua == ub;
            1: return ua != ub;
            2: return sa < sb;
            3: return sa > sb;
            4: return ua < ub;
            5: return ua > ub;
            6: return sa >= sb;
            7: return sa <= sb;
            8: return ua >= ub;
            9: return ua <= ub;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "next_pc", next_pc, m_npc);
        chk(tag, "taken", {31'd0, taken}, {31'd0, m_tk});
        chk(tag, "illegal", {31'd0, illegal}, {31'd0, m_ill});
        chk(tag, "br_done", {31'd0, br_done}, {31'd0, m_done});
    endtask

    // Called at a falling edge; drives one cycle and checks one edge later.
    task automatic cyc(input bit cv, input logic [31:0] a, input logic [31:0] b,
                       input bit bv, input int c, input logic [9:0] off,
                       input logic [31:0] p, input string tag);
        int signed disp;
        cmp_valid = cv; cmp_a = a; cmp_b = b;
        br_valid = bv; br_cond = 4'(c); br_offset = off; pc = p;
        m_done = bv; m_tk = 0; m_ill = 0;
        if (bv) begin
            if (c > 9) begin
                m_ill = 1; m_npc = p;
            end else if (rel(c, m_a, m_b)) begin
                disp = (off >= 10'h200) ? int'(off) - 1024 : int'(off);
                m_tk = 1; m_npc = p + 32'd2 + 32'(disp * 2);
            end else begin
                m_npc = p + 32'd2;
            end
        end
        if (cv) begin
            m_a = a; m_b = b;
        end
        @(posedge clk);
        @(negedge clk);
        cmp_valid = 0; br_valid = 0;
        compare_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic [31:0] pa [6] = '{32'd5, 32'd3, 32'd7, 32'hFFFF_FFFF, 32'd1, 32'h8000_0000};
    logic [31:0] pb [6] = '{32'd5, 32'd7, 32'd3, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF};

    initial begin
        repeat (3) @(negedge clk);
        compare_all("R1 in reset");
        rst_n = 1;
        @(negedge clk);
        compare_all("R1 after release");
        // latches reset to zero: code 0x0 compares 0 with 0
        cyc(0, 0, 0, 1, 0, 10'h004, 32'h0000_1000, "R1 eq on reset latches");
        cyc(0, 0, 0, 0, 0, 0, 0, "R10 idle after branch");
        cyc(1, 32'h11, 32'h22, 0, 0, 0, 32'h55, "R2 compare only");
        cyc(0, 0, 0, 1, 1, 10'h010, 32'h200, "R5 ne after compare");
        cyc(0, 0, 0, 1, 0, 10'h010, 32'h200, "R5 eq after compare");

        for (int i = 0; i < 6; i++) begin
            cyc(1, pa[i], pb[i], 0, 0, 0, 0, "R2 load pair");
            for (int c = 0; c < 10; c++) begin
                cyc(0, 0, 0, 1, c, 10'h3F0 + 10'(c), 32'h0000_4000 + 32'(c * 64),
                    (c < 2) ? "R5 eq/ne" : ((c == 4 || c == 5 || c == 8 || c == 9)
                    ? "R7 unsigned" : "R6 signed"));
            end
        end

        cyc(1, 9, 9, 0, 0, 0, 0, "R2 load equal");
        cyc(0, 0, 0, 1, 0, 10'h1FF, 32'h0000_2000, "R3 max positive offset");
        cyc(0, 0, 0, 1, 0, 10'h200, 32'h0000_2000, "R3 max negative offset");
        cyc(0, 0, 0, 1, 0, 10'h3FF, 32'h0000_2000, "R3 offset minus one");
        cyc(0, 0, 0, 1, 0, 10'h000, 32'hFFFF_FFFE, "R3 wrap at top");
        cyc(0, 0, 0, 1, 0, 10'h200, 32'h0000_0010, "R3 wrap below zero");
        cyc(0, 0, 0, 1, 1, 10'h1FF, 32'h0000_3000, "R4 not taken ignores offset");

        for (int c = 10; c < 16; c++)
            cyc(0, 0, 0, 1, c, 10'h00C, 32'h0000_6000 + 32'(c), "R8 illegal code");
        cyc(0, 0, 0, 0, 0, 0, 0, "R10 hold after illegal");

        // same-cycle compare and branch: latches hold 9/9, new pair differs
        cyc(1, 32'd1, 32'd2, 1, 0, 10'h008, 32'h700, "R9 old latches used");
        cyc(0, 0, 0, 1, 4, 10'h008, 32'h700, "R9 new latches later");
        cyc(0, 0, 0, 0, 0, 0, 0, "R10 idle");
        cyc(0, 0, 0, 0, 0, 0, 0, "R10 idle hold");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule